// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Unit

This block is purely combinational. It forms the second operand that a 32-bit ALU consumes, and it produces the carry bit that the shift or rotate generates. A select input chooses between two encodings of a 12-bit operand field.

In the constant form, the field holds an 8-bit value and a 4-bit rotate count. In the register form, the field holds a shift kind, a selector for where the amount comes from, and a 5-bit amount. The register form shifts the value of a source register, passed in on `rm_val`. The amount is either the 5-bit field or the low byte of a second register, passed in on `rs_val`.

The carry-out always reports the last bit that moved out of the word. If nothing moved, it reports the incoming carry flag. Writing the flags back is left to the surrounding datapath.

Top module: `bsh_operand2`

## Requirements
- R1: With `use_imm`=1, the operand is the zero-extended 8-bit value in field bits 7:0, rotated right by twice the 4-bit count in bits 11:8, so the rotation is even and lies between 0 and 30.
- R2: In the constant form, the carry-out equals `carry_in` when the count is 0, and equals bit 31 of the operand otherwise.
- R3: With `use_imm`=0 and field bit 4 = 0, the 5-bit amount in bits 11:7 applies to the shift kind in bits 6:5, where 00 is logical left, 01 is logical right, 10 is arithmetic right (sign kept) and 11 is rotate right. For an amount from 1 to 31, the carry-out is the last bit shifted out; for a rotate, this is operand bit 31. Field bits 3:0 have no effect.
- R4: A logical left shift by a field amount of 0 passes `rm_val` unchanged, and the carry-out equals `carry_in`.
- R5: A field amount of 0 with logical right means a shift of 32, giving 0 with carry `rm_val[31]`. With arithmetic right, it gives 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R6: A rotate right with a field amount of 0 is a one-bit rotate through the carry. The operand is `{carry_in, rm_val[31:1]}` and the carry-out is `rm_val[0]`.
- R7: With field bit 4 = 1, the amount is `rs_val[7:0]`, and `rs_val[31:8]` has no effect. An amount of 0 passes `rm_val` unchanged, with carry-out equal to `carry_in`, for every kind.
- R8: With a register amount from 1 to 31, the four kinds behave as in R3.
- R9: With a register amount of 32, logical left gives 0 with carry `rm_val[0]`, and logical right gives 0 with carry `rm_val[31]`. Above 32, both give 0 with carry 0. Arithmetic right with any amount of 32 or more gives 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R10: A register-amount rotate uses the amount modulo 32. A nonzero multiple of 32 gives `rm_val` unchanged with carry `rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| use_imm | input | 1 | 1 selects the rotated-constant form, 0 selects the register form |
| op_field | input | 12 | Operand field of the instruction |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Register whose low byte gives the shift amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Carry produced by the shift or rotate |

## Verification
The modulo reduction of the register-amount rotate and the zero-amount pass-through can coincide. Both return `rm_val` unchanged, but they must report different carries: `rm_val[31]` for the reduction and `carry_in` for the pass-through. Directed vectors place amounts of 0, 32, 64 and up to 224 in the low byte of `rs_val`, with random upper bits and the opposite `carry_in`. Each case is judged by its carry-out against the bench's doubled-word rotate model. Random fields also land on the constant-form count of 0, where the same question of carry source arises.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned FIELD_W     = 12;
  localparam int unsigned IMM_W       = 8;
  localparam int unsigned ROT_W       = 4;
  localparam int unsigned AMT_IMM_W   = 5;
  localparam int unsigned AMT_REG_W   = 8;
  localparam int unsigned KIND_W      = 2;
  localparam int unsigned SEL_BIT     = 4;
  localparam int unsigned KIND_LSB    = 5;
  localparam int unsigned AMT_IMM_LSB = 7;
  localparam int unsigned ROT_LSB     = IMM_W;
  localparam int unsigned AMT_W       = AMT_REG_W;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [AMT_W-1:0]   amt_t;
  typedef logic [FIELD_W-1:0] field_t;

  typedef enum logic [2:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR, SH_RRX} sh_kind_e;

  typedef struct packed {
    word_t value;
    logic  carry;
  } sh_res_t;

  function automatic sh_res_t f_lsl(word_t v, amt_t a, logic cin);
    sh_res_t r;
    word_t t;
    int unsigned n;
    n = 32'(a);
    r.value = v;
    r.carry = cin;
    if (n != 0 && n < DATA_W) begin
      t = v << (n - 1);
      r.value = t << 1;
      r.carry = t[DATA_W-1];
    end else if (n == DATA_W) begin
      r.value = '0;
      r.carry = v[0];
    end else if (n > DATA_W) begin
      r.value = '0;
      r.carry = 1'b0;
    end
    return r;
  endfunction

  function automatic sh_res_t f_lsr(word_t v, amt_t a, logic cin);
    sh_res_t r;
    word_t t;
    int unsigned n;
    n = 32'(a);
    r.value = v;
    r.carry = cin;
    if (n != 0 && n < DATA_W) begin
      t = v >> (n - 1);
      r.value = t >> 1;
      r.carry = t[0];
    end else if (n == DATA_W) begin
      r.value = '0;
      r.carry = v[DATA_W-1];
    end else if (n > DATA_W) begin
      r.value = '0;
      r.carry = 1'b0;
    end
    return r;
  endfunction

  function automatic sh_res_t f_asr(word_t v, amt_t a, logic cin);
    sh_res_t r;
    word_t t;
    int unsigned n;
    n = 32'(a);
    r.value = v;
    r.carry = cin;
    if (n != 0 && n < DATA_W) begin
      t = word_t'($signed(v) >>> (n - 1));
      r.value = word_t'($signed(t) >>> 1);
      r.carry = t[0];
    end else if (n >= DATA_W) begin
      r.value = {DATA_W{v[DATA_W-1]}};
      r.carry = v[DATA_W-1];
    end
    return r;
  endfunction

  function automatic sh_res_t f_ror(word_t v, amt_t a, logic cin);
    sh_res_t r;
    int unsigned n;
    int unsigned k;
    n = 32'(a);
    k = n % DATA_W;
    r.value = v;
    r.carry = cin;
    if (n != 0) begin
      if (k == 0) begin
        r.value = v;
      end else begin
        r.value = (v >> k) | (v << (DATA_W - k));
      end
      r.carry = r.value[DATA_W-1];
    end
    return r;
  endfunction

  function automatic sh_res_t f_rrx(word_t v, logic cin);
    sh_res_t r;
    r.value = {cin, v[DATA_W-1:1]};
    r.carry = v[0];
    return r;
  endfunction

  function automatic sh_res_t f_shift(sh_kind_e k, word_t v, amt_t a, logic cin);
    sh_res_t r;
    unique case (k)
      SH_LSL:  r = f_lsl(v, a, cin);
      SH_LSR:  r = f_lsr(v, a, cin);
      SH_ASR:  r = f_asr(v, a, cin);
      SH_ROR:  r = f_ror(v, a, cin);
      default: r = f_rrx(v, cin);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bsh_imm_decode.sv
module bsh_imm_decode
  import bsh_pkg::*;
(
  input  field_t field,
  input  logic   carry_in,
  output word_t  imm_value,
  output logic   imm_carry,
  output amt_t   rot_amt
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;

  logic [ROT_W-1:0] rot_cnt;
  word_t            base;
  sh_res_t          rot_res;

  // rotation is twice the count, so append a zero bit
  assign rot_cnt = field[ROT_LSB +: ROT_W];
  assign rot_amt = amt_t'({rot_cnt, 1'b0});
  assign base    = {{PAD_W{1'b0}}, field[IMM_W-1:0]};

  always_comb begin
    rot_res = f_ror(base, rot_amt, carry_in);
  end

  assign imm_value = rot_res.value;
  assign imm_carry = rot_res.carry;
endmodule

// File: rtl/bsh_amount_sel.sv
module bsh_amount_sel
  import bsh_pkg::*;
(
  input  field_t   field,
  input  word_t    rs_val,
  output sh_kind_e kind,
  output amt_t     amt,
  output logic     reg_amt_mode,
  output logic     fld_amt_zero
);
  logic [KIND_W-1:0]    kind_code;
  logic [AMT_IMM_W-1:0] fld_amt;
  amt_t                 reg_amt;

  assign kind_code    = field[KIND_LSB +: KIND_W];
  assign fld_amt      = field[AMT_IMM_LSB +: AMT_IMM_W];
  assign reg_amt      = rs_val[AMT_REG_W-1:0];
  assign reg_amt_mode = field[SEL_BIT];
  assign fld_amt_zero = (fld_amt == '0);

  always_comb begin
    kind = SH_LSL;
    amt  = '0;
    if (reg_amt_mode) begin
      amt = reg_amt;
      unique case (kind_code)
        2'b00:   kind = SH_LSL;
        2'b01:   kind = SH_LSR;
        2'b10:   kind = SH_ASR;
        default: kind = SH_ROR;
      endcase
    end else begin
      amt = amt_t'(fld_amt);
      unique case (kind_code)
        2'b00: kind = SH_LSL;
        2'b01: begin
          kind = SH_LSR;
          if (fld_amt_zero) amt = amt_t'(DATA_W);
        end
        2'b10: begin
          kind = SH_ASR;
          if (fld_amt_zero) amt = amt_t'(DATA_W);
        end
        default: kind = fld_amt_zero ? SH_RRX : SH_ROR;
      endcase
    end
  end
endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core
  import bsh_pkg::*;
(
  input  sh_kind_e kind,
  input  amt_t     amt,
  input  word_t    src,
  input  logic     carry_in,
  output word_t    sh_value,
  output logic     sh_carry
);
  sh_res_t res;

  always_comb begin
    res = f_shift(kind, src, amt, carry_in);
  end

  assign sh_value = res.value;
  assign sh_carry = res.carry;
endmodule

// File: rtl/bsh_operand2.sv
module bsh_operand2
  import bsh_pkg::*;
(
  input  logic        use_imm,
  input  logic [11:0] op_field,
  input  logic [31:0] rm_val,
  input  logic [31:0] rs_val,
  input  logic        carry_in,
  output logic [31:0] operand,
  output logic        carry_out
);
  word_t    imm_value;
  logic     imm_carry;
  amt_t     rot_amt;
  sh_kind_e sh_kind;
  amt_t     sh_amt;
  logic     reg_amt_mode;
  logic     fld_amt_zero;
  word_t    sh_value;
  logic     sh_carry;

  bsh_imm_decode u_imm (
    .field     (op_field),
    .carry_in  (carry_in),
    .imm_value (imm_value),
    .imm_carry (imm_carry),
    .rot_amt   (rot_amt)
  );

  bsh_amount_sel u_amt (
    .field        (op_field),
    .rs_val       (rs_val),
    .kind         (sh_kind),
    .amt          (sh_amt),
    .reg_amt_mode (reg_amt_mode),
    .fld_amt_zero (fld_amt_zero)
  );

  bsh_shift_core u_core (
    .kind     (sh_kind),
    .amt      (sh_amt),
    .src      (rm_val),
    .carry_in (carry_in),
    .sh_value (sh_value),
    .sh_carry (sh_carry)
  );

  assign operand   = use_imm ? imm_value : sh_value;
  assign carry_out = use_imm ? imm_carry : sh_carry;
endmodule

// File: rtl/bsh_operand2_chk.sv
module bsh_operand2_chk
  import bsh_pkg::*;
(
  input logic        use_imm,
  input logic [11:0] op_field,
  input logic [31:0] rm_val,
  input logic [31:0] rs_val,
  input logic        carry_in,
  input logic [31:0] operand,
  input logic        carry_out,
  input sh_kind_e    sh_kind,
  input amt_t        rot_amt
);
  always_comb begin
    if (use_imm && rot_amt == '0) begin
      AST_IMM_NOROT: assert (operand[31:8] == '0 && carry_out == carry_in) else $error("immediate rotate 0"); // R1
    end
    if (use_imm && rot_amt != '0) begin
      AST_IMM_CARRY: assert (carry_out == operand[31]) else $error("immediate carry"); // R2
    end
    if (!use_imm && !op_field[4] && op_field[6:5] == 2'b00 && op_field[11:7] == '0) begin
      AST_LSL_ZERO: assert (operand == rm_val && carry_out == carry_in) else $error("lsl 0"); // R4
    end
    if (!use_imm && !op_field[4] && op_field[6:5] == 2'b11 && op_field[11:7] == '0) begin
      AST_RRX_FORM: assert (sh_kind == SH_RRX && operand == {carry_in, rm_val[31:1]} && carry_out == rm_val[0]) else $error("rrx"); // R6
    end
    if (!use_imm && op_field[4] && rs_val[7:0] == '0) begin
      AST_REG_ZERO: assert (operand == rm_val && carry_out == carry_in) else $error("reg amount 0"); // R7
    end
    if (!use_imm && op_field[4] && rs_val[7:0] > 8'd32 && !op_field[6]) begin
      AST_BIG_ZERO: assert (operand == '0 && carry_out == 1'b0) else $error("logical over 32"); // R9
    end
    if (!use_imm && op_field[4] && op_field[6:5] == 2'b11 && rs_val[7:0] != '0 && rs_val[4:0] == '0) begin
      AST_ROR_WRAP: assert (operand == rm_val && carry_out == rm_val[31]) else $error("ror multiple of 32"); // R10
    end
  end
endmodule

bind bsh_operand2 bsh_operand2_chk u_chk (
  .use_imm   (use_imm),
  .op_field  (op_field),
  .rm_val    (rm_val),
  .rs_val    (rs_val),
  .carry_in  (carry_in),
  .operand   (operand),
  .carry_out (carry_out),
  .sh_kind   (sh_kind),
  .rot_amt   (rot_amt)
);

// File: tb/bsh_operand2_test.sv
module bsh_operand2_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        use_imm = 1'b0;
  logic [11:0] op_field = '0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand;
  logic        carry_out;
  int          n_checks = 0;
  int          n_errors = 0;
  int          cycles = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  bsh_operand2 uut (
    .use_imm   (use_imm),
    .op_field  (op_field),
    .rm_val    (rm_val),
    .rs_val    (rs_val),
    .carry_in  (carry_in),
    .operand   (operand),
    .carry_out (carry_out)
  );

  // reference model: doubled words, independent of the design's functions
  function automatic logic [32:0] model(logic ui, logic [11:0] f, logic [31:0] rm,
                                        logic [31:0] rs, logic ci);
    logic [63:0] d;
    logic [31:0] res;
    logic        c;
    int          n;
    int          typ;
    logic        rrx;
    rrx = 1'b0;
    if (ui) begin
      n = 2 * int'(f[11:8]);
      d = {24'b0, f[7:0], 24'b0, f[7:0]} >> n;
      res = d[31:0];
      c = (n == 0) ? ci : res[31];
      return {res, c};
    end
    typ = int'(f[6:5]);
    if (!f[4]) begin
      n = int'(f[11:7]);
      if (n == 0 && (typ == 1 || typ == 2)) n = 32;
      if (n == 0 && typ == 3) rrx = 1'b1;
    end else begin
      n = int'(rs[7:0]);
    end
    if (rrx) return {ci, rm[31:1], rm[0]};
    if (n == 0) return {rm, ci};
    case (typ)
      0: begin
        if (n >= 64) return 33'b0;
        d = {32'b0, rm} << n;
        return {d[31:0], d[32]};
      end
      1: begin
        if (n >= 64) return 33'b0;
        d = {rm, 32'b0} >> n;
        return {d[63:32], d[31]};
      end
      2: begin
        d = $signed({rm, 32'b0}) >>> ((n > 33) ? 33 : n);
        return {d[63:32], d[31]};
      end
      default: begin
        d = {rm, rm} >> (n % 32);
        res = d[31:0];
        return {res, res[31]};
      end
    endcase
  endfunction

  task automatic run(input logic ui, input logic [11:0] f, input logic [31:0] rm,
                     input logic [31:0] rs, input logic ci, input string tag);
    logic [32:0] exp;
    @(negedge clk);
    use_imm = ui; op_field = f; rm_val = rm; rs_val = rs; carry_in = ci;
    #2;
    exp = model(ui, f, rm, rs, ci);
    n_checks++;
    if ({operand, carry_out} !== exp) begin
      n_errors++;
      $display("FAIL %s: field=%h rm=%h rs=%h ci=%b actual=%h/%b expected=%h/%b",
               tag, f, rm, rs, ci, operand, carry_out, exp[32:1], exp[0]);
    end
  endtask

  function automatic string tag_of(logic ui, logic [11:0] f, logic [31:0] rs);
    if (ui) return (f[11:8] == 0) ? "R2" : "R1";
    if (!f[4]) begin
      if (f[11:7] != 0) return "R3";
      case (f[6:5])
        2'b00: return "R4";
        2'b11: return "R6";
        default: return "R5";
      endcase
    end
    if (rs[7:0] == 0) return "R7";
    if (f[6:5] == 2'b11) return "R10";
    if (rs[7:0] < 8'd32) return "R8";
    return "R9";
  endfunction

  function automatic logic [11:0] fr(int amt5, int typ, logic regsel, int low4);
    return {5'(amt5), 2'(typ), regsel, 4'(low4)};
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give zero
    @(negedge clk); #2;
    n_checks++;
    if (operand !== 32'h0 || carry_out !== 1'b0) begin
      n_errors++;
      $display("FAIL R4: reset state actual=%h/%b expected=0/0", operand, carry_out);
    end
    // R1 / R2 constant form
    run(1'b1, 12'h0FF, 32'h0, 32'h0, 1'b1, "R2");
    run(1'b1, 12'h0FF, 32'h0, 32'h0, 1'b0, "R2");
    run(1'b1, 12'hD40, 32'h0, 32'h0, 1'b0, "R1");
    run(1'b1, 12'h4FF, 32'h0, 32'h0, 1'b0, "R1");
    run(1'b1, 12'hF81, 32'h0, 32'h0, 1'b0, "R2");
    run(1'b1, 12'h102, 32'h0, 32'h0, 1'b1, "R2");
    // R3 field amounts, low bits ignored
    for (int t = 0; t < 4; t++) begin
      run(1'b0, fr(1, t, 1'b0, 9), 32'h8000_0001, 32'h0, 1'b0, "R3");
      run(1'b0, fr(31, t, 1'b0, 3), 32'hC000_0003, 32'h0, 1'b1, "R3");
    end
    // R4..R6 zero field amounts
    run(1'b0, fr(0, 0, 1'b0, 0), 32'hDEAD_BEEF, 32'h0, 1'b1, "R4");
    run(1'b0, fr(0, 1, 1'b0, 0), 32'h8000_0000, 32'h0, 1'b0, "R5");
    run(1'b0, fr(0, 2, 1'b0, 0), 32'h8000_0000, 32'h0, 1'b0, "R5");
    run(1'b0, fr(0, 2, 1'b0, 0), 32'h7FFF_FFFF, 32'h0, 1'b1, "R5");
    run(1'b0, fr(0, 3, 1'b0, 0), 32'h0000_0001, 32'h0, 1'b0, "R6");
    run(1'b0, fr(0, 3, 1'b0, 0), 32'h0000_0002, 32'h0, 1'b1, "R6");
    // R7..R10 register amounts, upper rs bits random
    for (int t = 0; t < 4; t++) begin
      run(1'b0, fr(int'($urandom % 32), t, 1'b1, 0), 32'hA5A5_0F0F,
          {24'($urandom), 8'd0}, 1'b1, "R7");
      run(1'b0, fr(0, t, 1'b1, 0), 32'h8000_0001, 32'hFFFF_FF10, 1'b0, "R8");
      run(1'b0, fr(0, t, 1'b1, 0), 32'h8000_0001, 32'd32, 1'b0, "R9");
      run(1'b0, fr(0, t, 1'b1, 0), 32'h8000_0001, 32'd33, 1'b1, "R9");
      run(1'b0, fr(0, t, 1'b1, 0), 32'h8000_0001, 32'd255, 1'b1, "R9");
    end
    for (int m = 1; m < 8; m++) begin
      run(1'b0, fr(0, 3, 1'b1, 0), 32'h1234_5678 ^ $urandom,
          {24'($urandom), 8'(m * 32)}, 1'b1, "R10");
    end
    run(1'b0, fr(0, 3, 1'b1, 0), 32'h0000_00F1, 32'd36, 1'b0, "R10");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic        ui;
      logic [11:0] f;
      logic [31:0] rm;
      logic [31:0] rs;
      logic        ci;
      ui = 1'($urandom);
      f  = 12'($urandom);
      rm = $urandom;
      rs = $urandom;
      ci = 1'($urandom);
      case ($urandom % 4)
        0: rs[7:0] = 8'($urandom % 40);
        1: rs[7:0] = 8'(($urandom % 8) * 32);
        2: f[11:7] = 5'b0;
        default: ;
      endcase
      run(ui, f, rm, rs, ci, tag_of(ui, f, rs));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule